// File: doc/BRIEF.md
# Synaptic Event Fan-Out Engine

The block sits between a spiking source array and a receiving array. Each incoming spike carries nothing but the sender's address; when it arrives is the only timing it has. The engine turns that address into a burst of weighted synaptic events. It first reads a per-sender pointer record, which gives a start index and a length into a contiguous list of connection entries. It then walks those entries in list order. Each entry names a target address and carries three release parameters: a repeat count, a release probability and an amplitude.

Every repeat slot of an entry draws from a 16-bit maximal-length shift register. The slot is delivered as an output event only when the draw clears the entry's probability. A slot that is not released still costs one cycle. Both tables can be rewritten while traffic flows. The pointer record is captured when a spike is accepted. Entry writes that would change the spike being expanded are held off until its expansion ends.

The engine is a three-state machine. IDLE accepts a spike and captures its pointer record. A zero length stays in IDLE (transition *drop*); any other length goes to FETCH (transition *accept*). FETCH latches one entry. A zero repeat count takes *skip*, which moves to the next entry or back to IDLE. Otherwise it takes *arm* into EMIT. EMIT spends one slot per repeat. On the last repeat it returns to FETCH (transition *next*) or to IDLE (transition *done*).

Top module: `aer_fanout`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, ent_wready is 1, and every pointer record has length 0.
- R2: An accepted spike with address a uses pointer record a (start, length). A length of 0 drops the spike: no event is produced and in_ready stays 1 on the following cycle.
- R3: Entries start..start+length-1 are expanded in increasing index order. Entry k produces n_k consecutive repeat slots before entry k+1 begins. An entry with n = 0 produces no slot.
- R4: The shift register starts at 0xACE1. Each step shifts it left by one and puts bits 15^13^12^10 into bit 0. The draw is bits 15:8. A slot is released when p = 255 or draw < p, so p = 0 never releases. The register steps exactly once at the end of each repeat slot.
- R5: A released slot raises out_valid with out_post and out_q equal to the entry's target and amplitude. A suppressed slot lasts one cycle and does not raise out_valid.
- R6: After an accepted spike, in_ready stays low for one fetch cycle per entry plus one cycle per completed repeat slot. The cycle right after acceptance never carries out_valid.
- R7: While out_valid is 1 and out_ready is 0, the event, its fields and the shift register all hold.
- R8: A pointer write is accepted on any cycle. It is used by the next spike accepted after the write.
- R9: While a spike is being expanded, ent_wready is 0 for addresses inside that spike's entry range. An entry write is committed only when ent_we and ent_wready are both 1. A write blocked this way changes nothing until the expansion ends, and then applies to later spikes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Spike offered |
| in_ready | output | 1 | Engine can take a spike |
| in_pre | input | PRE_W | Sender address of the spike |
| out_valid | output | 1 | Released event present |
| out_ready | input | 1 | Receiver takes the event |
| out_post | output | POST_W | Target address of the event |
| out_q | output | Q_W | Amplitude of the event |
| ptr_we | input | 1 | Pointer record write strobe |
| ptr_waddr | input | PRE_W | Sender address of the record written |
| ptr_wstart | input | IDX_W | First entry index |
| ptr_wcount | input | IDX_W+1 | Number of entries |
| ent_we | input | 1 | Entry write strobe |
| ent_wready | output | 1 | Entry write can be committed |
| ent_waddr | input | IDX_W | Entry index written |
| ent_wpost | input | POST_W | Target address field |
| ent_wn | input | N_W | Repeat count field |
| ent_wp | input | 8 | Release probability field |
| ent_wq | input | Q_W | Amplitude field |

## Verification
Several properties are checked on every cycle:
- a stalled event, its fields and the shift register stay stable;
- the cycle after acceptance carries no output;
- out_valid never coexists with in_ready;
- the shift register never reaches zero;
- entry writes are never refused while idle.

Other behaviours can only be shown by the bench's scenarios, run against a behavioural reference:
- the order and count of events per spike, including skipped entries;
- exactly which slots are released at p = 0, p = 128 and p = 255;
- dropped spikes;
- the moment a pointer rewrite starts to apply;
- a blocked entry write landing only on later spikes.

// File: rtl/aer_fanout_pkg.sv
package aer_fanout_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } fan_state_t;

    localparam int RND_W    = 16;
    localparam int DRAW_W   = 8;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;
    localparam logic [RND_W-1:0] RND_TAPS = 16'hB400;
endpackage

// File: rtl/aer_ptr_table.sv
module aer_ptr_table #(
    parameter int PRE_W = 6,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PRE_W-1:0] waddr,
    input  logic [IDX_W-1:0] wstart,
    input  logic [IDX_W:0]   wcount,
    input  logic [PRE_W-1:0] raddr,
    output logic [IDX_W-1:0] rstart,
    output logic [IDX_W:0]   rcount
);
    localparam int DEPTH = 1 << PRE_W;

    logic [IDX_W-1:0] start_mem [DEPTH];
    logic [IDX_W:0]   count_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                start_mem[i] <= '0;
                count_mem[i] <= '0;
            end
        end else if (we) begin
            start_mem[waddr] <= wstart;
            count_mem[waddr] <= wcount;
        end
    end

    assign rstart = start_mem[raddr];
    assign rcount = count_mem[raddr];
endmodule

// File: rtl/aer_entry_table.sv
module aer_entry_table #(
    parameter int IDX_W  = 6,
    parameter int POST_W = 10,
    parameter int N_W    = 4,
    parameter int P_W    = 8,
    parameter int Q_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [POST_W-1:0] wpost,
    input  logic [N_W-1:0]    wn,
    input  logic [P_W-1:0]    wp,
    input  logic [Q_W-1:0]    wq,
    input  logic [IDX_W-1:0]  ridx,
    output logic [POST_W-1:0] rpost,
    output logic [N_W-1:0]    rn,
    output logic [P_W-1:0]    rp,
    output logic [Q_W-1:0]    rq
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int EW    = POST_W + N_W + P_W + Q_W;

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= {wpost, wn, wp, wq};
        end
    end

    assign {rpost, rn, rp, rq} = mem[ridx];
endmodule

// File: rtl/aer_release_lfsr.sv
module aer_release_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);
    logic fb;
    assign fb = ^(state & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= SEED;
        else if (adv) state <= {state[W-2:0], fb};
    end
endmodule

// File: rtl/aer_fanout.sv
module aer_fanout
    import aer_fanout_pkg::*;
#(
    parameter int PRE_W  = 6,
    parameter int IDX_W  = 6,
    parameter int POST_W = 10,
    parameter int N_W    = 4,
    parameter int Q_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PRE_W-1:0]  in_pre,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [POST_W-1:0] out_post,
    output logic [Q_W-1:0]    out_q,
    input  logic              ptr_we,
    input  logic [PRE_W-1:0]  ptr_waddr,
    input  logic [IDX_W-1:0]  ptr_wstart,
    input  logic [IDX_W:0]    ptr_wcount,
    input  logic              ent_we,
    output logic              ent_wready,
    input  logic [IDX_W-1:0]  ent_waddr,
    input  logic [POST_W-1:0] ent_wpost,
    input  logic [N_W-1:0]    ent_wn,
    input  logic [DRAW_W-1:0] ent_wp,
    input  logic [Q_W-1:0]    ent_wq
);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);
    localparam logic [N_W-1:0]   ONE_REP  = N_W'(1);
    localparam logic [DRAW_W-1:0] P_ALL   = '1;

    fan_state_t st, nxt;

    logic [IDX_W-1:0]  p_start;
    logic [CNT_W-1:0]  p_count;
    logic [POST_W-1:0] e_post;
    logic [N_W-1:0]    e_n;
    logic [DRAW_W-1:0] e_p;
    logic [Q_W-1:0]    e_q;

    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  left;
    logic [IDX_W-1:0]  span_lo;
    logic [CNT_W-1:0]  span_hi;
    logic [N_W-1:0]    rep;
    logic [POST_W-1:0] cur_post;
    logic [DRAW_W-1:0] cur_p;
    logic [Q_W-1:0]    cur_q;

    logic [RND_W-1:0]  rnd_state;
    logic [DRAW_W-1:0] draw;
    logic              release_hit;
    logic              slot_done;
    logic              in_span;
    logic              ent_commit;

    aer_ptr_table #(.PRE_W(PRE_W), .IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .we(ptr_we), .waddr(ptr_waddr), .wstart(ptr_wstart), .wcount(ptr_wcount),
        .raddr(in_pre), .rstart(p_start), .rcount(p_count)
    );

    aer_entry_table #(.IDX_W(IDX_W), .POST_W(POST_W), .N_W(N_W), .P_W(DRAW_W), .Q_W(Q_W)) u_ent (
        .clk(clk), .rst_n(rst_n),
        .we(ent_commit), .waddr(ent_waddr),
        .wpost(ent_wpost), .wn(ent_wn), .wp(ent_wp), .wq(ent_wq),
        .ridx(idx), .rpost(e_post), .rn(e_n), .rp(e_p), .rq(e_q)
    );

    aer_release_lfsr #(.W(RND_W), .SEED(RND_SEED), .TAPS(RND_TAPS)) u_rnd (
        .clk(clk), .rst_n(rst_n), .adv(slot_done), .state(rnd_state)
    );

    // Release decision for the current repeat slot
    assign draw        = rnd_state[RND_W-1 -: DRAW_W];
    assign release_hit = (cur_p == P_ALL) || (draw < cur_p);
    assign slot_done   = (st == ST_EMIT) && (!release_hit || out_ready);

    // Entry writes that hit the spike in flight are held off
    assign in_span    = ({1'b0, ent_waddr} >= {1'b0, span_lo}) && ({1'b0, ent_waddr} < span_hi);
    assign ent_commit = ent_we && ent_wready;

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (in_valid && (p_count != '0)) nxt = ST_FETCH;
            end
            ST_FETCH: begin
                if (e_n != '0)            nxt = ST_EMIT;
                else if (left == ONE_LEFT) nxt = ST_IDLE;
            end
            ST_EMIT: begin
                if (slot_done && rep == ONE_REP)
                    nxt = (left == ONE_LEFT) ? ST_IDLE : ST_FETCH;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Walk counters and latched entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            left     <= '0;
            span_lo  <= '0;
            span_hi  <= '0;
            rep      <= '0;
            cur_post <= '0;
            cur_p    <= '0;
            cur_q    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (in_valid && (p_count != '0)) begin
                        idx     <= p_start;
                        left    <= p_count;
                        span_lo <= p_start;
                        span_hi <= {1'b0, p_start} + p_count;
                    end
                end
                ST_FETCH: begin
                    if (e_n != '0) begin
                        rep      <= e_n;
                        cur_post <= e_post;
                        cur_p    <= e_p;
                        cur_q    <= e_q;
                    end else if (left != ONE_LEFT) begin
                        idx  <= idx + IDX_W'(1);
                        left <= left - ONE_LEFT;
                    end
                end
                ST_EMIT: begin
                    if (slot_done) begin
                        if (rep == ONE_REP) begin
                            if (left != ONE_LEFT) begin
                                idx  <= idx + IDX_W'(1);
                                left <= left - ONE_LEFT;
                            end
                        end else begin
                            rep <= rep - ONE_REP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready   = (st == ST_IDLE);
        out_valid  = (st == ST_EMIT) && release_hit;
        out_post   = cur_post;
        out_q      = cur_q;
        ent_wready = (st == ST_IDLE) || !in_span;
    end
endmodule

// File: rtl/aer_fanout_chk.sv
module aer_fanout_chk #(
    parameter int POST_W = 10,
    parameter int Q_W    = 8,
    parameter int RND_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [POST_W-1:0] out_post,
    input logic [Q_W-1:0]    out_q,
    input logic              ent_wready,
    input logic [RND_W-1:0]  rnd
);
    AST_EVENT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_post) && $stable(out_q)); // R7

    AST_DRAW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(rnd)); // R7

    AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !out_valid); // R6

    AST_NO_EVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R6

    AST_RND_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0); // R4

    AST_WRITE_OPEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> ent_wready); // R9
endmodule

bind aer_fanout aer_fanout_chk #(.POST_W(POST_W), .Q_W(Q_W), .RND_W(16)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_post(out_post), .out_q(out_q),
    .ent_wready(ent_wready), .rnd(rnd_state)
);

// File: tb/aer_fanout_test.sv
module aer_fanout_test;
    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    logic        in_valid = 0, in_ready;
    logic [5:0]  in_pre = 0;
    logic        out_valid, out_ready = 1;
    logic [9:0]  out_post;
    logic [7:0]  out_q;
    logic        ptr_we = 0;
    logic [5:0]  ptr_waddr = 0, ptr_wstart = 0;
    logic [6:0]  ptr_wcount = 0;
    logic        ent_we = 0, ent_wready;
    logic [5:0]  ent_waddr = 0;
    logic [9:0]  ent_wpost = 0;
    logic [3:0]  ent_wn = 0;
    logic [7:0]  ent_wp = 0, ent_wq = 0;

    aer_fanout uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pre(in_pre),
        .out_valid(out_valid), .out_ready(out_ready), .out_post(out_post), .out_q(out_q),
        .ptr_we(ptr_we), .ptr_waddr(ptr_waddr), .ptr_wstart(ptr_wstart), .ptr_wcount(ptr_wcount),
        .ent_we(ent_we), .ent_wready(ent_wready), .ent_waddr(ent_waddr), .ent_wpost(ent_wpost),
        .ent_wn(ent_wn), .ent_wp(ent_wp), .ent_wq(ent_wq)
    );

    int checks = 0, errors = 0, ev_cnt = 0;
    bit bp_mode = 0, rdy_set = 1;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Receiver readiness, one driver
    always @(posedge clk) begin
        #2;
        out_ready <= bp_mode ? (($urandom % 3) != 0) : rdy_set;
    end

    // ---------------- behavioural reference ----------------
    typedef struct { bit ld; int post; int p; int q; } slot_t;
    slot_t mq[$];
    int m_ps[64], m_pc[64], m_post[64], m_n[64], m_p[64], m_q[64];
    int m_lo = 0, m_hi = 0;
    logic [15:0] m_rnd = 16'hACE1;

    function automatic bit m_rel(int p);
        return (p == 255) || (int'(m_rnd[15:8]) < p);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_rnd = 16'hACE1;
            foreach (m_ps[i]) begin
                m_ps[i] = 0; m_pc[i] = 0; m_post[i] = 0; m_n[i] = 0; m_p[i] = 0; m_q[i] = 0;
            end
        end else begin
            bit e_ir, e_ov, e_wr;
            int s, c;
            e_ir = (mq.size() == 0);
            e_ov = 0;
            if (!e_ir && !mq[0].ld) e_ov = m_rel(mq[0].p);
            e_wr = e_ir || !(int'(ent_waddr) >= m_lo && int'(ent_waddr) < m_hi);
            chk(in_ready == e_ir, "R6 in_ready", in_ready, e_ir);
            chk(out_valid == e_ov, "R4 out_valid", out_valid, e_ov);
            if (e_ov && out_valid) begin
                chk(int'(out_post) == mq[0].post, "R5 out_post", out_post, mq[0].post);
                chk(int'(out_q) == mq[0].q, "R5 out_q", out_q, mq[0].q);
            end
            chk(ent_wready == e_wr, "R9 ent_wready", ent_wready, e_wr);
            if (out_valid && out_ready) ev_cnt++;
            // next state
            s = m_ps[in_pre]; c = m_pc[in_pre];
            if (!e_ir) begin
                if (mq[0].ld) void'(mq.pop_front());
                else if (!(e_ov && !out_ready)) begin
                    m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
                    void'(mq.pop_front());
                end
            end
            if (ptr_we) begin m_ps[ptr_waddr] = ptr_wstart; m_pc[ptr_waddr] = ptr_wcount; end
            if (ent_we && e_wr) begin
                m_post[ent_waddr] = ent_wpost; m_n[ent_waddr] = ent_wn;
                m_p[ent_waddr] = ent_wp; m_q[ent_waddr] = ent_wq;
            end
            if (e_ir && in_valid && c > 0) begin
                m_lo = s; m_hi = s + c;
                for (int k = s; k < s + c; k++) begin
                    slot_t sl;
                    sl.ld = 1; sl.post = 0; sl.p = 0; sl.q = 0;
                    mq.push_back(sl);
                    for (int r = 0; r < m_n[k]; r++) begin
                        sl.ld = 0; sl.post = m_post[k]; sl.p = m_p[k]; sl.q = m_q[k];
                        mq.push_back(sl);
                    end
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wptr(int a, int s, int c);
        ptr_we = 1; ptr_waddr = a; ptr_wstart = s; ptr_wcount = c;
        @(posedge clk); #1 ptr_we = 0;
    endtask

    task automatic went(int a, int post, int n, int p, int q);
        ent_we = 1; ent_waddr = a; ent_wpost = post; ent_wn = n; ent_wp = p; ent_wq = q;
        do @(negedge clk); while (!ent_wready);
        @(posedge clk); #1 ent_we = 0;
    endtask

    task automatic spike(int a);
        in_pre = a; in_valid = 1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1 in_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int busy;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
        chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        chk(ent_wready == 1, "R1 ent_wready after reset", ent_wready, 1);
        @(posedge clk); #1;

        // R1/R2: unprogrammed sender is dropped
        ev_cnt = 0;
        spike(3);
        @(negedge clk);
        chk(in_ready == 1, "R2 dropped spike keeps ready", in_ready, 1);
        @(posedge clk); #1;
        chk(ev_cnt == 0, "R2 dropped spike events", ev_cnt, 0);

        // R3: ordered expansion with a skipped entry
        went(0, 11, 2, 255, 8'h21);
        went(1, 12, 0, 255, 8'h22);
        went(2, 13, 3, 255, 8'h23);
        wptr(5, 0, 3);
        ev_cnt = 0;
        spike(5);
        wait_idle();
        chk(ev_cnt == 5, "R3 event count for sender 5", ev_cnt, 5);

        // R4/R6: p = 0 never releases, busy for 1 + 4 cycles; R8 pointer rewrite while busy
        went(8, 40, 4, 0, 9);
        wptr(7, 8, 1);
        ev_cnt = 0;
        spike(7);
        wptr(7, 0, 1);
        busy = 1;
        @(negedge clk);
        while (!in_ready) begin busy++; @(negedge clk); end
        @(posedge clk); #1;
        chk(busy == 5, "R6 busy cycles for p=0 entry", busy, 5);
        chk(ev_cnt == 0, "R4 p=0 releases nothing", ev_cnt, 0);
        ev_cnt = 0;
        spike(7);
        wait_idle();
        chk(ev_cnt == 2, "R8 rewritten pointer used", ev_cnt, 2);

        // R4/R7: half probability under backpressure
        went(10, 50, 15, 128, 8'h55);
        wptr(9, 10, 1);
        bp_mode = 1;
        spike(9);
        wait_idle();
        spike(9);
        wait_idle();
        bp_mode = 0;
        @(posedge clk); #1;

        // R9: entry write inside the active span is held off
        rdy_set = 0;
        @(posedge clk); #1;
        ev_cnt = 0;
        spike(5);
        ent_we = 1; ent_waddr = 20; ent_wpost = 60; ent_wn = 1; ent_wp = 255; ent_wq = 1;
        @(negedge clk);
        chk(ent_wready == 1, "R9 write outside span accepted", ent_wready, 1);
        @(posedge clk); #1;
        ent_waddr = 1; ent_wpost = 99; ent_wn = 1; ent_wp = 255; ent_wq = 8'h77;
        @(negedge clk);
        chk(ent_wready == 0, "R9 write inside span held", ent_wready, 0);
        @(posedge clk); #1 rdy_set = 1;
        do @(negedge clk); while (!ent_wready);
        @(posedge clk); #1 ent_we = 0;
        wait_idle();
        chk(ev_cnt == 5, "R9 held write not used by active spike", ev_cnt, 5);
        ev_cnt = 0;
        spike(5);
        wait_idle();
        chk(ev_cnt == 6, "R9 held write used by next spike", ev_cnt, 6);

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule